// File: doc/BRIEF.md
# Memory Address and Data Port

This block sits between a processor's internal data bus and an external memory bus. An address register captures a value from the internal bus and drives the external address lines. A data register can take a word from either bus and can present its word on either bus. The processor's control sequencer decides when the address register loads, when the data register loads from or drives the internal bus, and when a read or a write starts.

Memory timing is not fixed. After a read or write starts, the block holds its request line high until the memory raises a completion flag. The memory raises this flag only when read data are valid, or when a write has been accepted. On a read, the data register captures the external data word in the cycle in which completion is sampled. On a write, the data register drives the external data lines for as long as the write request is held.

A busy output lets the sequencer stall while an access is outstanding. Start commands that arrive while the port is busy are dropped.

Top module: `mem_port`

## Requirements
- R1: After reset, `memRd`, `memWr`, `busy`, `extDataOutEn` and `intBusOutEn` are 0. `memAddr` is 0, and the data register holds 0.
- R2: When `marLoad` is 1 at a clock edge, `memAddr` shows the `intBusIn` value sampled at that edge from the next cycle on. Without `marLoad`, `memAddr` holds its value.
- R3: When `mdrLoadInt` is 1 at a clock edge and no read completes there, the data register takes `intBusIn`. While `mdrDriveInt` is 1, `intBusOutEn` is 1 and `intBusOut` equals the data register. While `mdrDriveInt` is 0, both are 0.
- R4: A `startRead` pulse sampled while the port is idle raises `memRd` and `busy` from the next cycle. Both stay 1 up to and including the cycle in which `memDone` is sampled 1, and both are 0 in the following cycle.
- R5: At the edge where a read completes (`memRd` = 1 and `memDone` = 1), the data register captures `extDataIn`.
- R6: A `startWrite` pulse sampled while the port is idle raises `memWr`, `busy` and `extDataOutEn` from the next cycle, with `extDataOut` equal to the data register. All three drop in the cycle after `memDone` is sampled 1. While no write is pending, `extDataOut` is 0.
- R7: A `memDone` that arrives while no access is pending has no effect. The data register keeps its value, and no request is raised.
- R8: `startRead` or `startWrite` sampled while `busy` is 1 is ignored. When the pending access completes, the port returns to idle with both request lines at 0.
- R9: If `startRead` and `startWrite` are both 1 while the port is idle, the read is started and no write is issued.
- R10: If a read completes at the same edge where `mdrLoadInt` is 1, the data register takes `extDataIn` and discards `intBusIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| intBusIn | input | DATA_W | Value on the internal processor bus |
| marLoad | input | 1 | Load the address register from the internal bus |
| mdrLoadInt | input | 1 | Load the data register from the internal bus |
| mdrDriveInt | input | 1 | Present the data register on the internal bus |
| intBusOut | output | DATA_W | Data register value toward the internal bus, 0 when not driving |
| intBusOutEn | output | 1 | Internal bus drive enable |
| startRead | input | 1 | Begin a memory read at the current address |
| startWrite | input | 1 | Begin a memory write of the data register |
| busy | output | 1 | An access is outstanding |
| memAddr | output | ADDR_W | External address lines, always the address register |
| memRd | output | 1 | Read request to memory |
| memWr | output | 1 | Write request to memory |
| memDone | input | 1 | Memory function completed |
| extDataIn | input | DATA_W | Data lines from memory |
| extDataOut | output | DATA_W | Data lines toward memory |
| extDataOutEn | output | 1 | External data drive enable |

## Verification
Two events can hit the data register at the same edge: the capture at read completion, and a load from the internal bus. The bench holds `mdrLoadInt` high with a distinct `intBusIn` value in the exact cycle in which it returns `memDone`. It then reads the register back by driving it onto the internal bus and expects the memory word. A second overlap is a start command that arrives during an outstanding access, including one in the completion cycle. The bench judges this by watching the request lines stay low after completion.

// File: rtl/mem_port_pkg.sv
package mem_port_pkg;

  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_WRITE = 2'd2
  } portState_e;

  // Strobes from the sequencer to the datapath for the external side.
  typedef struct packed {
    logic captureMem;  // take external data into the data register
    logic driveMem;    // present the data register on the external bus
  } mdrStrobe_t;

endpackage

// File: rtl/mem_port_ctrl.sv
module mem_port_ctrl
  import mem_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startRead,
  input  logic       startWrite,
  input  logic       memDone,
  output logic       memRd,
  output logic       memWr,
  output logic       busy,
  output mdrStrobe_t strobe
);

  portState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      PORT_IDLE: begin
        if (startRead)       stateNext = PORT_READ;
        else if (startWrite) stateNext = PORT_WRITE;
      end
      PORT_READ:  if (memDone) stateNext = PORT_IDLE;
      PORT_WRITE: if (memDone) stateNext = PORT_IDLE;
      default:    stateNext = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PORT_IDLE;
    else       state <= stateNext;
  end

  assign memRd = (state == PORT_READ);
  assign memWr = (state == PORT_WRITE);
  assign busy  = (state != PORT_IDLE);

  assign strobe.captureMem = memRd && memDone;
  assign strobe.driveMem   = memWr;

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd && !memDone |=> memRd);

  // R4
  rd_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd && memDone |=> !memRd && !busy);

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr && !memDone |=> memWr);

  // R6
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr && memDone |=> !memWr && !busy);

  // R7
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && memDone && !startRead && !startWrite |=> !busy);

  // R9
  read_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startRead && startWrite |=> memRd && !memWr);

endmodule

// File: rtl/mem_port_dp.sv
module mem_port_dp
  import mem_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] intBusIn,
  input  logic              marLoad,
  input  logic              mdrLoadInt,
  input  logic              mdrDriveInt,
  input  mdrStrobe_t        strobe,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [DATA_W-1:0] intBusOut,
  output logic              intBusOutEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOutEn
);

  localparam int ADDR_SLICE = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [ADDR_W-1:0] marNext;

  // The address register is narrower or wider than the bus, depending on the parameters.
  generate
    if (ADDR_W <= DATA_W) begin : g_addrNarrow
      assign marNext = intBusIn[ADDR_SLICE-1:0];
    end else begin : g_addrWide
      assign marNext = {{(ADDR_W-DATA_W){1'b0}}, intBusIn};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)        mar <= '0;
    else if (marLoad) mar <= marNext;
  end

  // A memory capture outranks an internal-bus load.
  always_ff @(posedge clk) begin
    if (!rstN)                  mdr <= '0;
    else if (strobe.captureMem) mdr <= extDataIn;
    else if (mdrLoadInt)        mdr <= intBusIn;
  end

  assign memAddr      = mar;
  assign intBusOutEn  = mdrDriveInt;
  assign intBusOut    = mdrDriveInt ? mdr : '0;
  assign extDataOutEn = strobe.driveMem;
  assign extDataOut   = strobe.driveMem ? mdr : '0;

  // R2
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !marLoad |=> $stable(mar));

  // R2
  mar_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    marLoad |=> mar == $past(marNext));

  // R5
  // R10
  mdr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureMem |=> mdr == $past(extDataIn));

  // R7
  mdr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureMem && !mdrLoadInt |=> $stable(mdr));

endmodule

// File: rtl/mem_port.sv
module mem_port
  import mem_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] intBusIn,
  input  logic              marLoad,
  input  logic              mdrLoadInt,
  input  logic              mdrDriveInt,
  output logic [DATA_W-1:0] intBusOut,
  output logic              intBusOutEn,
  input  logic              startRead,
  input  logic              startWrite,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  input  logic              memDone,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOutEn
);

  mdrStrobe_t strobe;

  mem_port_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startRead  (startRead),
    .startWrite (startWrite),
    .memDone    (memDone),
    .memRd      (memRd),
    .memWr      (memWr),
    .busy       (busy),
    .strobe     (strobe)
  );

  mem_port_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .intBusIn     (intBusIn),
    .marLoad      (marLoad),
    .mdrLoadInt   (mdrLoadInt),
    .mdrDriveInt  (mdrDriveInt),
    .strobe       (strobe),
    .extDataIn    (extDataIn),
    .intBusOut    (intBusOut),
    .intBusOutEn  (intBusOutEn),
    .memAddr      (memAddr),
    .extDataOut   (extDataOut),
    .extDataOutEn (extDataOutEn)
  );

  // R6
  ext_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    extDataOutEn |-> memWr && !memRd);

endmodule

// File: tb/mem_port_tb.sv
module mem_port_tb;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] intBusIn = '0;
  logic              marLoad = 1'b0;
  logic              mdrLoadInt = 1'b0;
  logic              mdrDriveInt = 1'b0;
  logic [DATA_W-1:0] intBusOut;
  logic              intBusOutEn;
  logic              startRead = 1'b0;
  logic              startWrite = 1'b0;
  logic              busy;
  logic [ADDR_W-1:0] memAddr;
  logic              memRd;
  logic              memWr;
  logic              memDone = 1'b0;
  logic [DATA_W-1:0] extDataIn = '0;
  logic [DATA_W-1:0] extDataOut;
  logic              extDataOutEn;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .intBusIn(intBusIn), .marLoad(marLoad),
    .mdrLoadInt(mdrLoadInt), .mdrDriveInt(mdrDriveInt),
    .intBusOut(intBusOut), .intBusOutEn(intBusOutEn),
    .startRead(startRead), .startWrite(startWrite), .busy(busy),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memDone(memDone),
    .extDataIn(extDataIn), .extDataOut(extDataOut), .extDataOutEn(extDataOutEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock edge; returns just after the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peekMdr(output logic [31:0] val);
    mdrDriveInt = 1'b1;
    #1;
    val = intBusOut;
    mdrDriveInt = 1'b0;
    #1;
  endtask

  task automatic loadMdr(input logic [31:0] val);
    intBusIn = val;
    mdrLoadInt = 1'b1;
    tick();
    mdrLoadInt = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 memRd", memRd, 0);
    chk("R1 memWr", memWr, 0);
    chk("R1 busy", busy, 0);
    chk("R1 extDataOutEn", extDataOutEn, 0);
    chk("R1 intBusOutEn", intBusOutEn, 0);
    chk("R1 memAddr", memAddr, 0);
    peekMdr(v);
    chk("R1 mdr", v, 0);
  endtask

  task automatic t_mar();
    intBusIn = 32'h0001_A5C3;
    marLoad = 1'b1;
    tick();
    marLoad = 1'b0;
    chk("R2 load", memAddr, 32'hA5C3);
    intBusIn = 32'h0000_1111;
    tick();
    chk("R2 hold", memAddr, 32'hA5C3);
  endtask

  task automatic t_mdrInt();
    logic [31:0] v;
    loadMdr(32'hDEAD_BEEF);
    chk("R3 no drive data", intBusOut, 0);
    chk("R3 no drive en", intBusOutEn, 0);
    mdrDriveInt = 1'b1;
    #1;
    chk("R3 drive en", intBusOutEn, 1);
    mdrDriveInt = 1'b0;
    #1;
    peekMdr(v);
    chk("R3 drive data", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_read(input int wait_cycles, input logic [31:0] data);
    logic [31:0] v;
    startRead = 1'b1;
    tick();
    startRead = 1'b0;
    for (int i = 0; i < wait_cycles; i++) begin
      chk("R4 rd held", memRd, 1);
      chk("R4 busy held", busy, 1);
      tick();
    end
    memDone = 1'b1;
    extDataIn = data;
    #1;
    chk("R4 rd in done cycle", memRd, 1);
    chk("R4 busy in done cycle", busy, 1);
    tick();
    memDone = 1'b0;
    extDataIn = 32'h5555_5555;
    chk("R4 rd dropped", memRd, 0);
    chk("R4 busy dropped", busy, 0);
    peekMdr(v);
    chk("R5 captured", v, data);
  endtask

  task automatic t_write();
    loadMdr(32'h1234_5678);
    chk("R6 idle ext data", extDataOut, 0);
    startWrite = 1'b1;
    tick();
    startWrite = 1'b0;
    chk("R6 wr", memWr, 1);
    chk("R6 rd low", memRd, 0);
    chk("R6 ext en", extDataOutEn, 1);
    chk("R6 ext data", extDataOut, 32'h1234_5678);
    tick();
    chk("R6 wr held", memWr, 1);
    chk("R6 busy held", busy, 1);
    memDone = 1'b1;
    tick();
    memDone = 1'b0;
    chk("R6 wr dropped", memWr, 0);
    chk("R6 ext en dropped", extDataOutEn, 0);
    chk("R6 busy dropped", busy, 0);
  endtask

  task automatic t_idleDone();
    logic [31:0] v;
    loadMdr(32'h0BAD_F00D);
    memDone = 1'b1;
    extDataIn = 32'hFFFF_0000;
    tick();
    memDone = 1'b0;
    chk("R7 no rd", memRd, 0);
    chk("R7 no busy", busy, 0);
    peekMdr(v);
    chk("R7 mdr kept", v, 32'h0BAD_F00D);
  endtask

  task automatic t_busyIgnore();
    startRead = 1'b1;
    tick();
    startRead = 1'b0;
    startWrite = 1'b1;
    tick();
    startWrite = 1'b0;
    chk("R8 no wr while reading", memWr, 0);
    memDone = 1'b1;
    startWrite = 1'b1;
    startRead = 1'b1;
    extDataIn = 32'h0000_0042;
    tick();
    memDone = 1'b0;
    startWrite = 1'b0;
    startRead = 1'b0;
    chk("R8 rd idle", memRd, 0);
    chk("R8 wr idle", memWr, 0);
    tick();
    chk("R8 still idle", busy, 0);
  endtask

  task automatic t_both();
    startRead = 1'b1;
    startWrite = 1'b1;
    tick();
    startRead = 1'b0;
    startWrite = 1'b0;
    chk("R9 rd chosen", memRd, 1);
    chk("R9 no wr", memWr, 0);
    memDone = 1'b1;
    tick();
    memDone = 1'b0;
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    startRead = 1'b1;
    tick();
    startRead = 1'b0;
    tick();
    memDone = 1'b1;
    extDataIn = 32'hCAFE_0001;
    mdrLoadInt = 1'b1;
    intBusIn = 32'h7777_7777;
    tick();
    memDone = 1'b0;
    mdrLoadInt = 1'b0;
    peekMdr(v);
    chk("R10 memory wins", v, 32'hCAFE_0001);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mar();
    t_mdrInt();
    t_read(0, 32'hA1B2_C3D4);
    t_read(3, 32'h0F0F_1234);
    t_write();
    t_idleDone();
    t_busyIgnore();
    t_both();
    t_conflict();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule